// File: doc/BRIEF.md
# ALU Operand Bypass Selector

This block decides, for each of the two ALU inputs of a five-stage in-order integer pipeline, where the operand value comes from. Its inputs are the source register numbers of the instruction now in the ALU stage, together with the destination tags of the two instructions ahead of it: the one whose ALU output sits in the Result register, and the one in the Write Back register. It picks the register file copy, the Result value or the Write Back value, and it drives the chosen operand. A second, smaller path covers the register-read stage. A register file read that hits the register being written back in the same cycle returns the new data.

The pipeline has delayed-load semantics. The instruction right after a load does not wait, and it sees the register's old value. The selector therefore never forwards from a load that sits in the Result register. When the Write Back register holds a load, its memory data is forwarded like any other result. The whole block is combinational and adds no cycle to the ALU stage.

Top module: `fwd_unit`

## Requirements
- R1: With no qualifying producer for a source register, its select code is 2'b00 and the operand equals the register file value carried into the ALU stage. The code 2'b11 never appears.
- R2: A Result producer qualifies when it is valid, writes a register, is not a load, and its destination is nonzero and equals the source. The select code is then 2'b01 and the operand equals the Result data.
- R3: A Write Back producer qualifies when it is valid, writes a register, and its destination is nonzero and equals the source. This holds whether the data came from memory or from the ALU. If no Result producer qualifies, the select code is 2'b10 and the operand equals the Write Back data.
- R4: When both producers qualify for the same source, the Result register wins (code 2'b01).
- R5: A load in the Result register whose destination matches a source is ignored for that source. Selection falls through to the Write Back register or the register file.
- R6: Source register 0 always gives select code 2'b00 and an operand of zero, even when a producer names register 0.
- R7: A producer whose valid bit or write-enable bit is low is never forwarded.
- R8: A register-read port whose address matches a valid, writing Write Back producer returns the Write Back data. Address 0 reads as zero. Any other address returns the raw register file data.
- R9: The two ALU inputs are resolved independently. A match on one input does not change the other input's select or value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register number of the ALU-stage instruction |
| ex_src_b | input | 5 | Second source register number of the ALU-stage instruction |
| ex_rf_a | input | 32 | Register file value carried for the first source |
| ex_rf_b | input | 32 | Register file value carried for the second source |
| res_vld | input | 1 | Result register holds a real instruction |
| res_wen | input | 1 | Result-stage instruction writes a register |
| res_load | input | 1 | Result-stage instruction is a load |
| res_rd | input | 5 | Destination register of the Result-stage instruction |
| res_data | input | 32 | Result register contents |
| wb_vld | input | 1 | Write Back register holds a real instruction |
| wb_wen | input | 1 | Write Back instruction writes a register |
| wb_rd | input | 5 | Destination register of the Write Back instruction |
| wb_data | input | 32 | Write Back register contents |
| id_addr_a | input | 5 | Register-read stage, first read address |
| id_addr_b | input | 5 | Register-read stage, second read address |
| id_raw_a | input | 32 | Raw register file data for the first read |
| id_raw_b | input | 32 | Raw register file data for the second read |
| sel_a | output | 2 | Select code for the first ALU input |
| sel_b | output | 2 | Select code for the second ALU input |
| opnd_a | output | 32 | First ALU operand |
| opnd_b | output | 32 | Second ALU operand |
| id_data_a | output | 32 | Bypassed first read value |
| id_data_b | output | 32 | Bypassed second read value |

## Verification
The bench draws register numbers from a small range so that producer matches, double matches and register 0 hits occur often. It also drives directed cases for each hazard.

- **Load in the Result register.** A design that forwarded it would hand the ALU data that does not yet exist, instead of the old value.
- **Double match.** Giving priority to the Write Back register would deliver a stale value.
- **Register 0.** A unit that forwarded it would let a producer named register 0 leak nonzero data.
- **Same-cycle read.** A read port without write-through would return the value from before the write.
- **Unqualified producers.** Bubbles and stores with matching tags must be ignored. The bench also checks that a hit on one operand leaves the other alone.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  // operand source codes; the ALU input mux decodes these
  typedef enum logic [1:0] {
    FWD_SEL_RF  = 2'b00,
    FWD_SEL_RES = 2'b01,
    FWD_SEL_WB  = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          res_vld,
  input  logic          res_wen,
  input  logic          res_load,
  input  logic [AW-1:0] res_rd,
  input  logic          wb_vld,
  input  logic          wb_wen,
  input  logic [AW-1:0] wb_rd,
  output fwd_sel_e      sel
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic src_live;
  logic res_hit;
  logic wb_hit;

  always_comb begin
    src_live = (src != ZERO_REG);
    // a load in the Result register is not yet available: delayed load
    res_hit  = src_live && res_vld && res_wen && !res_load && (res_rd == src);
    wb_hit   = src_live && wb_vld && wb_wen && (wb_rd == src);
    if (res_hit)     sel = FWD_SEL_RES;
    else if (wb_hit) sel = FWD_SEL_WB;
    else             sel = FWD_SEL_RF;
  end
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
  import fwd_pkg::*;
#(
  parameter int XW = 32
) (
  input  fwd_sel_e      sel,
  input  logic          src_zero,
  input  logic [XW-1:0] rf_val,
  input  logic [XW-1:0] res_data,
  input  logic [XW-1:0] wb_data,
  output logic [XW-1:0] opnd
);
  always_comb begin
    unique case (sel)
      FWD_SEL_RES: opnd = res_data;
      FWD_SEL_WB:  opnd = wb_data;
      default:     opnd = src_zero ? '0 : rf_val;
    endcase
  end
endmodule

// File: rtl/rf_bypass.sv
module rf_bypass #(
  parameter int AW = 5,
  parameter int XW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [XW-1:0] raw,
  input  logic          wb_vld,
  input  logic          wb_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic [XW-1:0] wb_data,
  output logic [XW-1:0] data
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  always_comb begin
    if (addr == ZERO_REG)                          data = '0;
    else if (wb_vld && wb_wen && (wb_rd == addr))  data = wb_data;
    else                                           data = raw;
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int AW = 5,
  parameter int XW = 32
) (
  input  logic [AW-1:0] ex_src_a,
  input  logic [AW-1:0] ex_src_b,
  input  logic [XW-1:0] ex_rf_a,
  input  logic [XW-1:0] ex_rf_b,
  input  logic          res_vld,
  input  logic          res_wen,
  input  logic          res_load,
  input  logic [AW-1:0] res_rd,
  input  logic [XW-1:0] res_data,
  input  logic          wb_vld,
  input  logic          wb_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic [XW-1:0] wb_data,
  input  logic [AW-1:0] id_addr_a,
  input  logic [AW-1:0] id_addr_b,
  input  logic [XW-1:0] id_raw_a,
  input  logic [XW-1:0] id_raw_b,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [XW-1:0] opnd_a,
  output logic [XW-1:0] opnd_b,
  output logic [XW-1:0] id_data_a,
  output logic [XW-1:0] id_data_b
);
  localparam int NPORT = 2;
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic [AW-1:0] src_v  [NPORT];
  logic [XW-1:0] rf_v   [NPORT];
  logic [AW-1:0] ida_v  [NPORT];
  logic [XW-1:0] idr_v  [NPORT];
  fwd_sel_e      sel_v  [NPORT];
  logic [XW-1:0] opnd_v [NPORT];
  logic [XW-1:0] idd_v  [NPORT];

  always_comb begin
    src_v[0] = ex_src_a;  src_v[1] = ex_src_b;
    rf_v[0]  = ex_rf_a;   rf_v[1]  = ex_rf_b;
    ida_v[0] = id_addr_a; ida_v[1] = id_addr_b;
    idr_v[0] = id_raw_a;  idr_v[1] = id_raw_b;
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    fwd_select #(.AW(AW)) u_sel (
      .src(src_v[i]), .res_vld(res_vld), .res_wen(res_wen), .res_load(res_load),
      .res_rd(res_rd), .wb_vld(wb_vld), .wb_wen(wb_wen), .wb_rd(wb_rd),
      .sel(sel_v[i])
    );
    fwd_opmux #(.XW(XW)) u_mux (
      .sel(sel_v[i]), .src_zero(src_v[i] == ZERO_REG), .rf_val(rf_v[i]),
      .res_data(res_data), .wb_data(wb_data), .opnd(opnd_v[i])
    );
    rf_bypass #(.AW(AW), .XW(XW)) u_byp (
      .addr(ida_v[i]), .raw(idr_v[i]), .wb_vld(wb_vld), .wb_wen(wb_wen),
      .wb_rd(wb_rd), .wb_data(wb_data), .data(idd_v[i])
    );

    always_comb begin
      AST_SEL_LEGAL: assert (sel_v[i] != 2'b11);  // R1
      if (sel_v[i] == FWD_SEL_RES)
        AST_RES_VALUE: assert (opnd_v[i] == res_data);  // R2
      if (sel_v[i] == FWD_SEL_WB)
        AST_WB_VALUE: assert (opnd_v[i] == wb_data);  // R3
      if (res_vld && res_wen && res_load && (res_rd == src_v[i]))
        AST_LOAD_NO_FWD: assert (sel_v[i] != FWD_SEL_RES);  // R5
      if (src_v[i] == ZERO_REG)
        AST_ZERO_SRC: assert (sel_v[i] == FWD_SEL_RF && opnd_v[i] == '0);  // R6
      if (!res_vld && !wb_vld)
        AST_IDLE_NO_FWD: assert (sel_v[i] == FWD_SEL_RF);  // R7
      if (ida_v[i] == ZERO_REG)
        AST_ID_ZERO: assert (idd_v[i] == '0);  // R8
    end
  end

  assign sel_a     = sel_v[0];
  assign sel_b     = sel_v[1];
  assign opnd_a    = opnd_v[0];
  assign opnd_b    = opnd_v[1];
  assign id_data_a = idd_v[0];
  assign id_data_b = idd_v[1];
endmodule

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb_top;
  logic clk;
  logic rst_n;
  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [4:0]  ex_src_a, ex_src_b, res_rd, wb_rd, id_addr_a, id_addr_b;
  logic [31:0] ex_rf_a, ex_rf_b, res_data, wb_data, id_raw_a, id_raw_b;
  logic        res_vld, res_wen, res_load, wb_vld, wb_wen;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b, id_data_a, id_data_b;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  fwd_unit dut_i (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
    .res_vld(res_vld), .res_wen(res_wen), .res_load(res_load), .res_rd(res_rd),
    .res_data(res_data), .wb_vld(wb_vld), .wb_wen(wb_wen), .wb_rd(wb_rd),
    .wb_data(wb_data), .id_addr_a(id_addr_a), .id_addr_b(id_addr_b),
    .id_raw_a(id_raw_a), .id_raw_b(id_raw_b), .sel_a(sel_a), .sel_b(sel_b),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .id_data_a(id_data_a), .id_data_b(id_data_b)
  );

  function automatic logic [1:0] exp_sel(input logic [4:0] s);
    if (s == 5'd0) return 2'b00;
    if (res_vld && res_wen && !res_load && res_rd == s) return 2'b01;
    if (wb_vld && wb_wen && wb_rd == s) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [31:0] exp_opnd(input logic [4:0] s, input logic [31:0] rf);
    case (exp_sel(s))
      2'b01:   return res_data;
      2'b10:   return wb_data;
      default: return (s == 5'd0) ? 32'd0 : rf;
    endcase
  endfunction

  function automatic logic [31:0] exp_id(input logic [4:0] a, input logic [31:0] raw);
    if (a == 5'd0) return 32'd0;
    if (wb_vld && wb_wen && wb_rd == a) return wb_data;
    return raw;
  endfunction

  function automatic string tag(input logic [4:0] s);
    if (s == 5'd0) return "R6";
    if (res_vld && res_wen && res_load && res_rd == s) return "R5";
    if (res_vld && res_wen && !res_load && res_rd == s)
      return (wb_vld && wb_wen && wb_rd == s) ? "R4" : "R2";
    if (wb_vld && wb_wen && wb_rd == s) return "R3";
    return "R1";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string note);
    @(negedge clk);
    chk({tag(ex_src_a), " sel_a ", note}, {30'd0, sel_a}, {30'd0, exp_sel(ex_src_a)});
    chk({tag(ex_src_a), " opnd_a ", note}, opnd_a, exp_opnd(ex_src_a, ex_rf_a));
    chk({tag(ex_src_b), " sel_b ", note}, {30'd0, sel_b}, {30'd0, exp_sel(ex_src_b)});
    chk({tag(ex_src_b), " opnd_b ", note}, opnd_b, exp_opnd(ex_src_b, ex_rf_b));
    chk({"R8 id_a ", note}, id_data_a, exp_id(id_addr_a, id_raw_a));
    chk({"R8 id_b ", note}, id_data_b, exp_id(id_addr_b, id_raw_b));
  endtask

  task automatic idle();
    ex_src_a = 5'd3; ex_src_b = 5'd4; ex_rf_a = 32'h1111_0003; ex_rf_b = 32'h1111_0004;
    res_vld = 0; res_wen = 0; res_load = 0; res_rd = 5'd0; res_data = 32'hAAAA_0001;
    wb_vld = 0; wb_wen = 0; wb_rd = 5'd0; wb_data = 32'hBBBB_0002;
    id_addr_a = 5'd3; id_addr_b = 5'd4; id_raw_a = 32'hC0C0_0003; id_raw_b = 32'hC0C0_0004;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0;
    idle();
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R1: idle pipeline, nothing forwarded
    check_all("idle");
    chk("R1 idle sel", {30'd0, sel_a}, 32'd0);

    // R2: ALU result forwarded to operand a only (R9: b untouched)
    idle(); res_vld = 1; res_wen = 1; res_rd = 5'd3;
    check_all("res");
    chk("R2 sel_a", {30'd0, sel_a}, 32'd1);
    chk("R9 sel_b", {30'd0, sel_b}, 32'd0);
    chk("R9 opnd_b", opnd_b, 32'h1111_0004);

    // R3: load data in Write Back forwarded
    idle(); wb_vld = 1; wb_wen = 1; wb_rd = 5'd4;
    check_all("wb");
    chk("R3 opnd_b", opnd_b, 32'hBBBB_0002);

    // R4: both match, Result wins
    idle(); res_vld = 1; res_wen = 1; res_rd = 5'd3; wb_vld = 1; wb_wen = 1; wb_rd = 5'd3;
    check_all("both");
    chk("R4 opnd_a", opnd_a, 32'hAAAA_0001);

    // R5: load in Result ignored, falls to Write Back
    res_load = 1;
    check_all("load");
    chk("R5 sel_a", {30'd0, sel_a}, 32'd2);
    wb_vld = 0;
    check_all("load-rf");
    chk("R5 opnd_a", opnd_a, 32'h1111_0003);

    // R6: register 0 with producers naming it
    idle(); ex_src_a = 5'd0; ex_rf_a = 32'hDEAD_BEEF; res_vld = 1; res_wen = 1; res_rd = 5'd0;
    wb_vld = 1; wb_wen = 1; wb_rd = 5'd0; id_addr_a = 5'd0;
    check_all("zero");
    chk("R6 opnd_a", opnd_a, 32'd0);

    // R7: bubble and store do not forward
    idle(); res_vld = 0; res_wen = 1; res_rd = 5'd3; wb_vld = 1; wb_wen = 0; wb_rd = 5'd4;
    check_all("unqual");
    chk("R7 opnd_a", opnd_a, 32'h1111_0003);
    chk("R7 opnd_b", opnd_b, 32'h1111_0004);

    // R8: same-cycle write-through at register read
    idle(); wb_vld = 1; wb_wen = 1; wb_rd = 5'd4; id_addr_b = 5'd4;
    check_all("wt");
    chk("R8 id_b", id_data_b, 32'hBBBB_0002);
    chk("R8 id_a", id_data_a, 32'hC0C0_0003);

    for (int n = 0; n < 3000; n++) begin
      ex_src_a = 5'($urandom_range(0, 3)); ex_src_b = 5'($urandom_range(0, 3));
      ex_rf_a = $urandom; ex_rf_b = $urandom;
      res_vld = 1'($urandom); res_wen = 1'($urandom); res_load = 1'($urandom);
      res_rd = 5'($urandom_range(0, 3)); res_data = $urandom;
      wb_vld = 1'($urandom); wb_wen = 1'($urandom);
      wb_rd = 5'($urandom_range(0, 3)); wb_data = $urandom;
      id_addr_a = 5'($urandom_range(0, 3)); id_addr_b = 5'($urandom_range(0, 31));
      id_raw_a = $urandom; id_raw_b = $urandom;
      check_all("rand");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule